// File: doc/BRIEF.md
# Bit-Swapping Low-Transition Pattern Generator

This block produces pseudorandom stimulus for built-in self-test. Its core is a maximal-length Fibonacci shift register. The register shifts toward its top bit and takes an XOR of its tap bits back into bit 0. The register's own state sequence is never altered.

On the output side, a row of 2:1 multiplexers sits between the register and the pattern bus. The top state bit acts as a shared select. When it is 1, every adjacent pair below it (bits 0/1, 2/3, and so on) trades places. When it is 0, all bits pass straight through. The top bit always goes out unchanged. Over a full period, the pattern bus carries the same set of words as the plain register, only in a different order, and it toggles noticeably less often.

The raw state is also brought out so that a checker can compare the two streams. The block has no stream handshake. A single enable pin paces it, and a low enable holds the state and both outputs unchanged, so the consumer applies back-pressure simply by lowering that pin. The width must be odd, and the default width is 7.

Top module: `bslfsr_gen`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets raw_state to the default seed 0x01, and pattern then also reads 0x01.
- R2: With en high and seed_load low, each clock edge turns state s into {s[W-2:0], f}. Here f is the XOR of the state bits selected by the tap mask, which for W=7 gives f = s[6]^s[5].
- R3: Started from any nonzero seed, raw_state returns to that seed after exactly 2^W-1 enabled clocks (127 for W=7), and not before.
- R4: seed_load high with a nonzero seed_val loads seed_val into raw_state at the next edge, whatever the level of en.
- R5: seed_load high with seed_val equal to zero loads the default seed 0x01 instead, so the register cannot lock up.
- R6: With en and seed_load both low, raw_state and pattern keep their values across clock edges.
- R7: When raw_state[W-1] is 0, pattern equals raw_state.
- R8: When raw_state[W-1] is 1, pattern[2k] = raw_state[2k+1] and pattern[2k+1] = raw_state[2k] for every k below (W-1)/2, and pattern[W-1] = raw_state[W-1].
- R9: Over one full period, pattern takes every nonzero W-bit value exactly once.
- R10: Over one full period, each pattern bit is 1 in exactly 2^(W-1) cycles (64 for W=7).
- R11: Over one full cyclic period, the total number of bit toggles on pattern is strictly lower than on raw_state. The raw_state total is W*2^(W-1) (448 for W=7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the register by one step |
| seed_load | input | 1 | Load seed_val (a zero value is replaced by the default seed) |
| seed_val | input | WIDTH | Seed value |
| pattern | output | WIDTH | Pair-swapped pattern for the circuit under test |
| raw_state | output | WIDTH | Unswapped register state |

## Verification
The assertions assume that the reset is held through the first clock edge, so that the state is never sampled as unknown. They also assume that a zero state cannot appear, because no port can load one. The stepping and hold properties assume that seed_load, en and seed_val are stable at each clock edge. The bench meets all of this by asserting reset from time zero and by driving every input only on falling edges. It loads zero only through the seed port, where it is replaced by the default seed.

// File: rtl/bslfsr_pkg.sv
package bslfsr_pkg;

  // Fibonacci tap masks (bit k set = stage k+1 feeds the XOR) for primitive polynomials
  function automatic logic [31:0] tap_mask(input int width);
    case (width)
      3:       tap_mask = 32'h0000_0006;
      5:       tap_mask = 32'h0000_0014;
      7:       tap_mask = 32'h0000_0060;
      9:       tap_mask = 32'h0000_0110;
      11:      tap_mask = 32'h0000_0500;
      13:      tap_mask = 32'h0000_100D;
      15:      tap_mask = 32'h0000_6000;
      17:      tap_mask = 32'h0001_2000;
      default: tap_mask = 32'h0000_0060;
    endcase
  endfunction

endpackage

// File: rtl/bslfsr_core.sv
module bslfsr_core #(
  parameter int WIDTH = 7,
  parameter logic [WIDTH-1:0] TAPS = WIDTH'(bslfsr_pkg::tap_mask(WIDTH)),
  parameter logic [WIDTH-1:0] DEFAULT_SEED = WIDTH'(1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load,
  input  logic [WIDTH-1:0] seed,
  output logic [WIDTH-1:0] state
);

  logic             fb_bit;
  logic [WIDTH-1:0] seed_safe;

  assign fb_bit    = ^(state & TAPS);
  assign seed_safe = (seed == '0) ? DEFAULT_SEED : seed;

  always_ff @(posedge clk) begin
    if (rst)       state <= DEFAULT_SEED;
    else if (load) state <= seed_safe;
    else if (en)   state <= {state[WIDTH-2:0], fb_bit};
  end

  AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (rst)
    state != '0); // R3
  AST_STEP_RULE: assert property (@(posedge clk) disable iff (rst)
    (en && !load) |=> state == {$past(state[WIDTH-2:0]), $past(^(state & TAPS))}); // R2
  AST_SEED_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (load && seed != '0) |=> state == $past(seed)); // R4
  AST_ZERO_SEED: assert property (@(posedge clk) disable iff (rst)
    (load && seed == '0) |=> state == DEFAULT_SEED); // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(state)); // R6

endmodule

// File: rtl/bslfsr_pair_swap.sv
module bslfsr_pair_swap #(
  parameter int WIDTH = 7
) (
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] pat
);

  localparam int NPAIRS = (WIDTH - 1) / 2;

  logic sel;
  assign sel = raw[WIDTH-1];

  for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
    assign pat[2*p]   = sel ? raw[2*p+1] : raw[2*p];
    assign pat[2*p+1] = sel ? raw[2*p]   : raw[2*p+1];
  end

  assign pat[WIDTH-1] = sel;

endmodule

// File: rtl/bslfsr_gen.sv
module bslfsr_gen #(
  parameter int WIDTH = 7,
  parameter logic [WIDTH-1:0] TAPS = WIDTH'(bslfsr_pkg::tap_mask(WIDTH)),
  parameter logic [WIDTH-1:0] DEFAULT_SEED = WIDTH'(1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             seed_load,
  input  logic [WIDTH-1:0] seed_val,
  output logic [WIDTH-1:0] pattern,
  output logic [WIDTH-1:0] raw_state
);

  logic [WIDTH-1:0] state_w;

  bslfsr_core #(
    .WIDTH(WIDTH), .TAPS(TAPS), .DEFAULT_SEED(DEFAULT_SEED)
  ) core_i (
    .clk(clk), .rst(rst), .en(en), .load(seed_load), .seed(seed_val), .state(state_w)
  );

  bslfsr_pair_swap #(.WIDTH(WIDTH)) swap_i (
    .raw(state_w), .pat(pattern)
  );

  assign raw_state = state_w;

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    !raw_state[WIDTH-1] |-> pattern == raw_state); // R7
  AST_SELECT_KEPT: assert property (@(posedge clk) disable iff (rst)
    pattern[WIDTH-1] == raw_state[WIDTH-1]); // R8
  AST_SWAP_PAIR0: assert property (@(posedge clk) disable iff (rst)
    raw_state[WIDTH-1] |-> (pattern[0] == raw_state[1] && pattern[1] == raw_state[0])); // R8
  AST_WEIGHT_KEPT: assert property (@(posedge clk) disable iff (rst)
    $countones(pattern) == $countones(raw_state)); // R9

endmodule

// File: tb/bslfsr_gen_tb_top.sv
module bslfsr_gen_tb_top;

  localparam int W = 7;
  localparam int PERIOD = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic         seed_load = 1'b0;
  logic [W-1:0] seed_val = '0;
  logic [W-1:0] pattern;
  logic [W-1:0] raw_state;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bslfsr_gen #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .en(en), .seed_load(seed_load), .seed_val(seed_val),
    .pattern(pattern), .raw_state(raw_state)
  );

  function automatic logic [W-1:0] m_step(input logic [W-1:0] s);
    return {s[W-2:0], s[6] ^ s[5]};
  endfunction

  function automatic logic [W-1:0] m_swap(input logic [W-1:0] s);
    logic [W-1:0] r;
    r = s;
    if (s[W-1]) begin
      for (int k = 0; k < (W-1)/2; k++) begin
        r[2*k]   = s[2*k+1];
        r[2*k+1] = s[2*k];
      end
    end
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic e, input logic ld, input logic [W-1:0] sv);
    en = e; seed_load = ld; seed_val = sv;
    @(negedge clk);
    en = 1'b0; seed_load = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R1 raw", int'(raw_state), 1);
    chk("R1 pattern", int'(pattern), 1);
  endtask

  task automatic t_step;
    logic [W-1:0] exp;
    cyc(1'b0, 1'b1, 7'h5A);
    exp = 7'h5A;
    for (int i = 0; i < 20; i++) begin
      cyc(1'b1, 1'b0, '0);
      exp = m_step(exp);
      chk("R2 step", int'(raw_state), int'(exp));
    end
  endtask

  task automatic t_load;
    cyc(1'b1, 1'b1, 7'h33);
    chk("R4 load with en", int'(raw_state), 'h33);
    cyc(1'b0, 1'b1, 7'h7F);
    chk("R4 load", int'(raw_state), 'h7F);
  endtask

  task automatic t_zero;
    cyc(1'b0, 1'b1, 7'h40);
    cyc(1'b1, 1'b1, 7'h00);
    chk("R5 zero seed", int'(raw_state), 1);
  endtask

  task automatic t_freeze;
    logic [W-1:0] r0, p0;
    cyc(1'b0, 1'b1, 7'h61);
    r0 = raw_state; p0 = pattern;
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 7'h12);
    chk("R6 raw held", int'(raw_state), int'(r0));
    chk("R6 pattern held", int'(pattern), int'(p0));
  endtask

  task automatic t_swap;
    cyc(1'b0, 1'b1, 7'h2D);
    chk("R7 pass", int'(pattern), 'h2D);
    cyc(1'b0, 1'b1, 7'h41);
    chk("R8 swap", int'(pattern), 'h42);
    cyc(1'b0, 1'b1, 7'h56);
    chk("R8 swap", int'(pattern), int'(m_swap(7'h56)));
    chk("R8 top bit", int'(pattern[W-1]), 1);
  endtask

  task automatic t_period;
    bit seen [0:PERIOD];
    int ones [W];
    int first_ret, raw_tr, pat_tr, mdl_tr;
    logic [W-1:0] prev_r, prev_p, ms, mp;
    for (int i = 0; i <= PERIOD; i++) seen[i] = 1'b0;
    for (int b = 0; b < W; b++) ones[b] = 0;
    first_ret = 0; raw_tr = 0; pat_tr = 0; mdl_tr = 0;
    cyc(1'b0, 1'b1, 7'h01);
    ms = 7'h01;
    for (int i = 1; i <= PERIOD; i++) begin
      prev_r = raw_state; prev_p = pattern;
      seen[pattern] = 1'b1;
      for (int b = 0; b < W; b++) ones[b] += int'(pattern[b]);
      mp = m_swap(ms);
      ms = m_step(ms);
      mdl_tr += $countones(mp ^ m_swap(ms));
      cyc(1'b1, 1'b0, '0);
      raw_tr += $countones(prev_r ^ raw_state);
      pat_tr += $countones(prev_p ^ pattern);
      if (raw_state == 7'h01 && first_ret == 0) first_ret = i;
    end
    chk("R3 period", first_ret, PERIOD);
    for (int v = 1; v <= PERIOD; v++) chk("R9 value seen", int'(seen[v]), 1);
    for (int b = 0; b < W; b++) chk("R10 ones count", ones[b], 1 << (W-1));
    chk("R11 raw toggles", raw_tr, W * (1 << (W-1)));
    chk("R11 pattern toggles", pat_tr, mdl_tr);
    chk("R11 fewer toggles", int'(pat_tr < raw_tr), 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_step();
    t_load();
    t_zero();
    t_freeze();
    t_swap();
    t_period();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule